// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to fifteen interrupt lines, decides which pending one matters most, and signals the processor over a single active-low request line. Each line has its own control register that sets a 3-bit priority and chooses between edge and level detection and between the two signal polarities. Software learns which source fired by reading a vector register on a small memory-mapped bus. The value returned is the source number, or zero when no source qualifies.

In normal operation that read is also the acknowledge. It retires the winning request and records the winner's priority on an internal eight-entry priority stack, so that only strictly more urgent sources can interrupt the handler. A write to the end-of-interrupt register pops the stack when the handler finishes. A mode bit moves the acknowledge from the read to a write of the vector register. With that bit set, a debugger can read the vector as often as it likes without changing any state.

Top module: `vpic_top`

## Requirements
- R1: After reset the mode register (byte offset 0x00, bit 0) reads 0, every control register reads 0x0000_0047, the vector register reads 0 and `irq_n` is high while all inputs are low.
- R2: Control register n (1..15) sits at byte offset 4*n. Bits [2:0] hold the priority (7 most urgent). Bit 6 set selects level detection and clear selects edge detection. Bit 7 set selects the active-low level or the falling edge, and clear selects active-high or rising. All other bits are ignored on write and read as 0.
- R3: The vector register (offset 0x40) returns the number of the qualifying source with the highest priority, with the lower number winning a tie. It returns 0 when no source qualifies.
- R4: A source qualifies only if its priority is strictly above the priority on top of the stack. When the stack is empty, any priority qualifies.
- R5: With mode bit 0 clear, a read of the vector register that returns a nonzero value acknowledges that source and pushes its priority on the stack.
- R6: With mode bit 0 set, reads of the vector register change no state, and repeated reads return the same value.
- R7: With mode bit 0 set, a write to the vector register performs the acknowledge and the push. With mode bit 0 clear, such a write has no effect.
- R8: A level source is requested while its input is at the active level. After it is acknowledged, it stays masked until its input leaves the active level.
- R9: An edge source latches a pending request on the selected edge, and only an acknowledge of that source clears it.
- R10: A write to the end-of-interrupt register (offset 0x44) pops the eight-entry stack. A pop of an empty stack is ignored.
- R11: `irq_n` is low exactly when some source qualifies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 15 | Interrupt inputs, bit i is source i+1, synchronous to clk |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its defaults: fifteen sources, 3-bit priorities and an eight-deep stack. Eight distinct priority levels therefore nest to exactly the full stack depth, which makes a complete fill and drain, plus an extra pop on the empty stack, reachable in a short directed run. All fifteen sources are present, so the register-index decode boundaries at both ends are exercised, and the random phase shuffles detection modes and polarities on every line.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

   // Register word indices fixed by software-visible behaviour.
   localparam int unsigned MODE_IDX   = 0;
   localparam int unsigned CTRL_FIRST = 1;

   // Bit positions inside a control register.
   localparam int unsigned LEVEL_BIT  = 6;
   localparam int unsigned INVERT_BIT = 7;

   // Word index of the vector register: first power of two above the control block.
   function automatic int unsigned vec_index(input int unsigned nsrc);
      return 2 ** $clog2(nsrc + 1);
   endfunction

endpackage

// File: rtl/vpic_src.sv
module vpic_src (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic level_i,
   input  logic invert_i,
   input  logic ack_i,
   output logic active_o
);
   logic prev_q, pend_q, mask_q;
   logic asserted, prev_asserted, edge_seen;

   assign asserted      = raw_i ^ invert_i;
   assign prev_asserted = prev_q ^ invert_i;
   assign edge_seen     = asserted & ~prev_asserted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
         mask_q <= 1'b0;
      end else begin
         prev_q <= raw_i;
         pend_q <= ~level_i & (edge_seen | (pend_q & ~ack_i));
         mask_q <= level_i & (ack_i | (mask_q & asserted));
      end
   end

   assign active_o = level_i ? (asserted & ~mask_q) : pend_q;

   // R9: a latched edge request survives until acknowledged
   a_r9_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_i && pend_q && !ack_i) |=> pend_q);

   // R8: an acknowledged level source stays masked while still asserted
   a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (level_i && mask_q && asserted && !ack_i) |=> mask_q);

endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
   parameter int unsigned NUM_SRC = 15,
   parameter int unsigned PRIO_W  = 3,
   localparam int unsigned VEC_W  = $clog2(NUM_SRC + 1),
   localparam int unsigned LVL_W  = PRIO_W + 1
) (
   input  logic [NUM_SRC-1:0]             active_i,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
   input  logic [LVL_W-1:0]               floor_i,
   output logic [VEC_W-1:0]               win_vec_o,
   output logic [PRIO_W-1:0]              win_prio_o,
   output logic                           win_any_o
);
   logic [NUM_SRC-1:0] eligible;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
      assign eligible[g] = active_i[g] &&
                           (({1'b0, prio_i[g]} + LVL_W'(1)) > floor_i);
   end

   always_comb begin
      win_vec_o  = '0;
      win_prio_o = '0;
      win_any_o  = 1'b0;
      for (int i = 0; i < int'(NUM_SRC); i++) begin
         if (eligible[i] && (!win_any_o || prio_i[i] > win_prio_o)) begin
            win_any_o  = 1'b1;
            win_prio_o = prio_i[i];
            win_vec_o  = VEC_W'(i + 1);
         end
      end
   end

endmodule

// File: rtl/vpic_stack.sv
module vpic_stack #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned PRIO_W = 3,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned LVL_W = PRIO_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [PRIO_W-1:0] push_val_i,
   input  logic              pop_i,
   output logic [LVL_W-1:0]  floor_o,
   output logic [CNT_W-1:0]  count_o
);
   logic [PRIO_W-1:0] mem_q [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic              full, empty;

   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign empty = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (push_i && !full) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end else if (pop_i && !push_i && !empty) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push_i && !full) mem_q[PTR_W'(cnt_q)] <= push_val_i;
   end

   assign floor_o = empty ? '0 : ({1'b0, mem_q[PTR_W'(cnt_q - CNT_W'(1))]} + LVL_W'(1));
   assign count_o = cnt_q;

   a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));

   a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && empty) |=> (cnt_q == '0));

endmodule

// File: rtl/vpic_top.sv
module vpic_top #(
   parameter int unsigned NUM_SRC = 15,
   parameter int unsigned PRIO_W  = 3,
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_n
);
   import vpic_pkg::*;

   localparam int unsigned VEC_W   = $clog2(NUM_SRC + 1);
   localparam int unsigned LVL_W   = PRIO_W + 1;
   localparam int unsigned CNT_W   = $clog2(DEPTH + 1);
   localparam int unsigned IDX_W   = ADDR_W - 2;
   localparam int unsigned VEC_IDX = vec_index(NUM_SRC);
   localparam int unsigned EOI_IDX = VEC_IDX + 1;

   // Elaboration-time parameter checks.
   if (PRIO_W < 1 || PRIO_W > LEVEL_BIT) begin : g_bad_prio
      $error("PRIO_W must be 1..%0d", LEVEL_BIT);
   end
   if (NUM_SRC < 1) begin : g_bad_nsrc
      $error("NUM_SRC must be at least 1");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end
   if (ADDR_W < $clog2(EOI_IDX + 1) + 2) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be at least 8");
   end

   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
   logic [NUM_SRC-1:0]             level_q, invert_q;
   logic                           debug_q;

   logic [IDX_W-1:0]   idx;
   logic               hit_mode, hit_vec, hit_eoi;
   logic [NUM_SRC-1:0] hit_ctrl;
   logic               ack_fire, pop;
   logic [NUM_SRC-1:0] active, ack_vec;
   logic [VEC_W-1:0]   win_vec;
   logic [PRIO_W-1:0]  win_prio;
   logic               win_any;
   logic [LVL_W-1:0]   floor_lvl;
   logic [CNT_W-1:0]   stk_count;

   assign idx      = bus_addr[ADDR_W-1:2];
   assign hit_mode = (idx == IDX_W'(MODE_IDX));
   assign hit_vec  = (idx == IDX_W'(VEC_IDX));
   assign hit_eoi  = (idx == IDX_W'(EOI_IDX));

   assign ack_fire = bus_sel && hit_vec && win_any && (debug_q ? bus_we : !bus_we);
   assign pop      = bus_sel && bus_we && hit_eoi;

   // Per-source configuration and request logic.
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      assign hit_ctrl[g] = (idx == IDX_W'(CTRL_FIRST + g));
      assign ack_vec[g]  = ack_fire && (win_vec == VEC_W'(g + 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_q[g]   <= '1;
            level_q[g]  <= 1'b1;
            invert_q[g] <= 1'b0;
         end else if (bus_sel && bus_we && hit_ctrl[g]) begin
            prio_q[g]   <= bus_wdata[PRIO_W-1:0];
            level_q[g]  <= bus_wdata[LEVEL_BIT];
            invert_q[g] <= bus_wdata[INVERT_BIT];
         end
      end

      vpic_src u_src (
         .clk      (clk),
         .rst_n    (rst_n),
         .raw_i    (src_in[g]),
         .level_i  (level_q[g]),
         .invert_i (invert_q[g]),
         .ack_i    (ack_vec[g]),
         .active_o (active[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             debug_q <= 1'b0;
      else if (bus_sel && bus_we && hit_mode) debug_q <= bus_wdata[0];
   end

   vpic_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
      .active_i   (active),
      .prio_i     (prio_q),
      .floor_i    (floor_lvl),
      .win_vec_o  (win_vec),
      .win_prio_o (win_prio),
      .win_any_o  (win_any)
   );

   vpic_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W)) u_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (ack_fire),
      .push_val_i (win_prio),
      .pop_i      (pop),
      .floor_o    (floor_lvl),
      .count_o    (stk_count)
   );

   // Read mux.
   always_comb begin
      bus_rdata = '0;
      if (hit_mode) bus_rdata[0] = debug_q;
      if (hit_vec)  bus_rdata[VEC_W-1:0] = win_vec;
      for (int i = 0; i < int'(NUM_SRC); i++) begin
         if (hit_ctrl[i]) begin
            bus_rdata[PRIO_W-1:0] = prio_q[i];
            bus_rdata[LEVEL_BIT]  = level_q[i];
            bus_rdata[INVERT_BIT] = invert_q[i];
         end
      end
   end

   assign irq_n = ~win_any;

   // R5: a normal-mode vector read with a winner grows the stack
   a_r5_push_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && hit_vec && !debug_q && win_any && stk_count < CNT_W'(DEPTH))
      |=> (stk_count == $past(stk_count) + CNT_W'(1)));

   // R6: a debug-mode vector read leaves the stack untouched
   a_r6_debug_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && hit_vec && debug_q) |=> $stable(stk_count));

   // R7: a normal-mode vector write leaves the stack untouched
   a_r7_normal_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && hit_vec && !debug_q) |=> $stable(stk_count));

   // R11: no request while the vector register would read zero
   a_r11_irq_vs_vec: assert property (@(posedge clk) disable iff (!rst_n)
      (win_vec == '0) |-> irq_n);

endmodule

// File: tb/vpic_top_tb_top.sv
module vpic_top_tb_top;
   localparam int N = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src = '0;
   logic          sel = 1'b0, we = 1'b0;
   logic [7:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq_n;

   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   vpic_top dut_i (
      .clk(clk), .rst_n(rst_n), .src_in(src), .bus_sel(sel), .bus_we(we),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_n(irq_n)
   );

   // Reference model state.
   int m_prio[N];
   bit m_lvl[N], m_inv[N], m_prev[N], m_pend[N], m_mask[N];
   int m_stk[8];
   int m_cnt;
   bit m_mode;

   function automatic int floor_lvl();
      return (m_cnt == 0) ? 0 : m_stk[m_cnt-1] + 1;
   endfunction

   function automatic int winner(logic [N-1:0] s);
      int best = 0, bp = -1;
      for (int i = 0; i < N; i++) begin
         bit asrt = s[i] ^ m_inv[i];
         bit act  = m_lvl[i] ? (asrt && !m_mask[i]) : m_pend[i];
         if (act && m_prio[i] + 1 > floor_lvl() && m_prio[i] > bp) begin
            bp = m_prio[i];
            best = i + 1;
         end
      end
      return best;
   endfunction

   function automatic logic [31:0] exp_read(logic [N-1:0] s, logic [7:0] a);
      int ix = a >> 2;
      if (ix == 0) return {31'b0, m_mode};
      if (ix >= 1 && ix <= N)
         return {24'b0, m_inv[ix-1], m_lvl[ix-1], 3'b0, 3'(m_prio[ix-1])};
      if (ix == 16) return 32'(winner(s));
      return 32'h0;
   endfunction

   task automatic m_update(logic [N-1:0] s, bit bs, bit bw, logic [7:0] a, logic [31:0] d);
      int  ix  = a >> 2;
      int  w   = winner(s);
      bit  ack = bs && ix == 16 && w != 0 && (m_mode ? bw : !bw);
      for (int i = 0; i < N; i++) begin
         bit asrt  = s[i] ^ m_inv[i];
         bit edg   = asrt && !(m_prev[i] ^ m_inv[i]);
         bit ackme = ack && (w == i + 1);
         m_pend[i] = !m_lvl[i] && (edg || (m_pend[i] && !ackme));
         m_mask[i] = m_lvl[i] && (ackme || (m_mask[i] && asrt));
         m_prev[i] = s[i];
      end
      if (ack && m_cnt < 8) begin
         m_stk[m_cnt] = m_prio[w-1];
         m_cnt++;
      end
      if (bs && bw && ix == 17 && m_cnt > 0) m_cnt--;
      if (bs && bw && ix >= 1 && ix <= N) begin
         m_prio[ix-1] = int'(d[2:0]);
         m_lvl[ix-1]  = d[6];
         m_inv[ix-1]  = d[7];
      end
      if (bs && bw && ix == 0) m_mode = d[0];
   endtask

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // One cycle: drive at the falling edge, compare, then advance the model.
   task automatic step(logic [N-1:0] s, bit bs, bit bw, logic [7:0] a,
                       logic [31:0] d, string tag);
      @(negedge clk);
      src = s; sel = bs; we = bw; addr = a; wdata = d;
      #1;
      check({tag, " irq_n (R11)"}, {31'b0, irq_n}, {31'b0, winner(s) == 0});
      if (bs && !bw) check({tag, " rdata"}, rdata, exp_read(s, a));
      m_update(s, bs, bw, a, d);
   endtask

   task automatic rd(logic [7:0] a, string tag);  step(src, 1, 0, a, 0, tag); endtask
   task automatic wr(logic [7:0] a, logic [31:0] d, string tag); step(src, 1, 1, a, d, tag); endtask
   task automatic idle(logic [N-1:0] s, string tag); step(s, 0, 0, 0, 0, tag); endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_prio[i] = 7; m_lvl[i] = 1; m_inv[i] = 0;
         m_prev[i] = 0; m_pend[i] = 0; m_mask[i] = 0;
      end
      m_cnt = 0; m_mode = 0;
      void'($urandom(32'h5eed_0042));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values, with explicit constants as well as the model
      rd(8'h00, "R1 mode");
      for (int n = 1; n <= N; n++) begin
         @(negedge clk); sel = 1; we = 0; addr = 8'(4 * n); #1;
         check("R1 ctrl reset 0x47", rdata, 32'h47);
         m_update(src, 1, 0, addr, 0);
      end
      rd(8'h40, "R1 vector");
      check("R1 irq_n high", {31'b0, irq_n}, 32'h1);

      // R10: pops on an empty stack are ignored
      repeat (3) wr(8'h44, 0, "R10 empty pop");
      rd(8'h40, "R10 after empty pops");

      // R2: field decode and ignored bits
      wr(8'h08, 32'hFFFF_FF3A, "R2 junk bits");
      rd(8'h08, "R2 readback masked");
      wr(8'h08, 32'h0000_00C5, "R2 inverted level");
      rd(8'h08, "R2 readback");
      rd(8'h40, "R2 active-low level with input low");
      wr(8'h40, 0, "R7 normal write ignored");
      rd(8'h40, "R7 still pending after write");
      rd(8'h40, "R5 read after ack");
      wr(8'h44, 0, "R10 pop");
      rd(8'h40, "R8 masked while asserted");
      idle(15'h0002, "R8 input inactive");
      idle(15'h0000, "R8 input active again");
      wr(8'h44, 0, "R10 extra pop");
      wr(8'h08, 32'h47, "R2 restore");

      // R3/R4/R6/R7: tie break, debug reads, debug acknowledge
      wr(8'h0C, 32'h43, "R3 cfg src3");
      wr(8'h14, 32'h43, "R3 cfg src5");
      idle(15'h0014, "R3 raise 3 and 5");
      wr(8'h00, 1, "R6 debug on");
      rd(8'h40, "R6 debug read 1");
      rd(8'h40, "R6 debug read 2");
      rd(8'h40, "R6 debug read 3");
      wr(8'h40, 0, "R7 debug write ack");
      rd(8'h40, "R4 equal priority blocked");
      wr(8'h44, 0, "R10 pop");
      rd(8'h40, "R8 src3 masked, src5 wins");
      idle(15'h0010, "R8 drop src3");
      idle(15'h0014, "R8 raise src3");
      rd(8'h40, "R3 tie lower number");
      wr(8'h00, 0, "R5 debug off");
      rd(8'h40, "R5 normal read acks");
      rd(8'h40, "R4 blocked at level");
      wr(8'h44, 0, "R10 pop");
      rd(8'h40, "R3 next winner");
      wr(8'h44, 0, "R10 pop");
      idle(15'h0000, "clear inputs");
      idle(15'h0000, "clear inputs");

      // R9: falling-edge latch, held until acknowledged
      wr(8'h1C, 32'h81, "R9 cfg src7 falling edge");
      idle(15'h0040, "R9 high");
      idle(15'h0000, "R9 falling edge");
      rd(8'h00, "R9 settle");
      idle(15'h0040, "R9 rise no clear");
      idle(15'h0000, "R9 second fall");
      wr(8'h00, 1, "R9 debug on");
      rd(8'h40, "R9 pending held");
      wr(8'h00, 0, "R9 debug off");
      rd(8'h40, "R9 ack");
      rd(8'h40, "R9 cleared");
      wr(8'h44, 0, "R10 pop");
      rd(8'h40, "R9 cleared after pop");

      // R10: fill all eight levels, then drain and over-pop
      for (int k = 0; k < 8; k++) wr(8'(4 * (8 + k)), 32'(k), "R10 cfg rising edge");
      for (int k = 0; k < 8; k++) begin
         logic [N-1:0] s;
         s = src; s[7 + k] = 1'b1;
         idle(s, "R10 edge");
         rd(8'h40, "R10 nest ack");
      end
      rd(8'h40, "R10 full stack");
      for (int k = 0; k < 9; k++) begin
         wr(8'h44, 0, "R10 drain");
         rd(8'h40, "R10 after pop");
      end

      // Random phase
      for (int t = 0; t < 4000; t++) begin
         logic [N-1:0] s;
         int r;
         s = src;
         if ($urandom % 3 == 0) s[$urandom % N] = ~s[$urandom % N];
         r = $urandom % 100;
         if (r < 25)      step(s, 1, 0, 8'h40, 0, "R3 random vector read");
         else if (r < 33) step(s, 1, 1, 8'h40, $urandom, "R7 random vector write");
         else if (r < 45) step(s, 1, 1, 8'h44, 0, "R10 random pop");
         else if (r < 53) step(s, 1, 1, 8'(4 * (1 + $urandom % N)), $urandom, "R2 random cfg");
         else if (r < 57) step(s, 1, 1, 8'h00, 32'($urandom % 2), "R6 random mode");
         else if (r < 67) step(s, 1, 0, 8'(4 * ($urandom % 18)), 0, "R2 random read");
         else             step(s, 0, 0, 0, 0, "R4 random idle");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule